// File: doc/BRIEF.md
# Masked Input-Change Interrupt Generator

This block turns level changes on a wide set of general-purpose pins into one interrupt request. The pins are grouped into banks of equal width. For each bank the block keeps a snapshot of the pin values as they stood when software last read that bank. Any pin that is set up as an input, whose interrupt mask bit is clear, and whose synchronised level differs from its snapshot, pulls the interrupt request active.

The output is an enable for an open-drain pad: when it is high the pad sinks current, and when it is low the pad lets go. The block never asks the pad to drive high. The register engine sends a one-cycle strobe with a bank number each time it reads an input bank. That strobe refreshes the bank's snapshot and withdraws the bank's share of the request on the same clock edge. Direction and mask are applied continuously. Read-value polarity inversion happens elsewhere and does not affect detection, because detection only ever looks at raw pin levels.

Top module: `chg_irq_gen`

## Requirements
- R1: While reset is high, and after it, `int_drive_low` is 0. Reset loads every snapshot from the pin levels present at reset, so pins that are left unchanged never raise the request, even after all masks are cleared.
- R2: The interrupt is a single pull-low enable: 1 means sink the pad, 0 means release it. No output drives the line high.
- R3: If a pin has `dir_in`=1 and `int_mask`=0, toggling it raises `int_drive_low` on the third rising clock edge after the change: two synchroniser flops, then the output register.
- R4: A pin with `dir_in`=0 (output) never causes the request, whatever its level does.
- R5: A pin with `int_mask`=1 never causes the request. Masks are expected to start at all ones.
- R6: A read strobe with `rd_bank`=b (banks numbered from 0; bank b covers pins b*BANK_W up to b*BANK_W+BANK_W-1) copies that bank's synchronised pins into its snapshot. On that same edge it drops the bank's contribution, so a request caused only by that bank is released at that edge and stays released.
- R7: A read of one bank leaves every other bank's snapshot and pending change in place.
- R8: If a changed pin goes back to its snapshot value before any read, the request is released on the third rising edge after it goes back.
- R9: A read strobe whose `rd_bank` is BANKS or higher has no effect.
- R10: Clearing the mask of a pin that already differs from its snapshot raises the request on the next rising edge. Setting the mask again releases it on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | BANKS*BANK_W | Raw pin levels, asynchronous |
| dir_in | input | BANKS*BANK_W | 1 = pin configured as input |
| int_mask | input | BANKS*BANK_W | 1 = pin barred from interrupting |
| rd_strobe | input | 1 | One-cycle pulse marking a read of an input bank |
| rd_bank | input | BSEL_W | Number of the bank being read |
| int_drive_low | output | 1 | Registered pad enable, 1 = pull interrupt line low |

## Verification
The hardest case to reach from the ports is a snapshot that differs from its pins while the request stays hidden. This happens when the change sits under a set mask or an output direction, and it only shows up once the mask is lifted. The sweep produces it on purpose. For every pin and every direction/mask combination, it toggles the pin while the pin is not qualified, confirms that the request stays quiet, then clears the mask and expects the request on the very next edge. It also checks that reads of a neighbouring bank or of an out-of-range bank leave a pending request standing, and that only a read of the pin's own bank clears it.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
  localparam int DEF_BANKS   = 5;
  localparam int DEF_BANK_W  = 8;
  localparam int SYNC_STAGES = 2;

  function automatic int sel_width(input int banks);
    return (banks > 1) ? $clog2(banks) : 1;
  endfunction
endpackage

// File: rtl/chg_irq_sync.sv
module chg_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= d;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/chg_irq_bank.sv
module chg_irq_bank #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] pin_raw,
  input  logic [BANK_W-1:0] pin_sync,
  input  logic [BANK_W-1:0] dir_in,
  input  logic [BANK_W-1:0] int_mask,
  input  logic              rd_hit,
  output logic [BANK_W-1:0] snap,
  output logic              flag
);
  logic [BANK_W-1:0] differs;

  always_ff @(posedge clk) begin
    if (rst)         snap <= pin_raw;
    else if (rd_hit) snap <= pin_sync;
  end

  always_comb begin
    differs = (pin_sync ^ snap) & dir_in & ~int_mask;
    flag    = |differs;
  end
endmodule

// File: rtl/chg_irq_out.sv
module chg_irq_out #(
  parameter int BANKS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BANKS-1:0] bank_flag,
  input  logic [BANKS-1:0] bank_read,
  output logic             int_drive_low
);
  logic req_next;

  always_comb req_next = |(bank_flag & ~bank_read);

  always_ff @(posedge clk) begin
    if (rst) int_drive_low <= 1'b0;
    else     int_drive_low <= req_next;
  end
endmodule

// File: rtl/chg_irq_gen.sv
module chg_irq_gen
  import chg_irq_pkg::*;
#(
  parameter int BANKS  = DEF_BANKS,
  parameter int BANK_W = DEF_BANK_W,
  parameter int N_PINS = BANKS * BANK_W,
  parameter int BSEL_W = sel_width(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] dir_in,
  input  logic [N_PINS-1:0] int_mask,
  input  logic              rd_strobe,
  input  logic [BSEL_W-1:0] rd_bank,
  output logic              int_drive_low
);
  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] snap_all;
  logic [BANKS-1:0]  bank_flag;
  logic [BANKS-1:0]  bank_read;

  chg_irq_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_i),
    .q   (pin_sync)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    assign bank_read[b] = rd_strobe && (rd_bank == BSEL_W'(b));

    chg_irq_bank #(.BANK_W(BANK_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .pin_raw  (pin_i[LO +: BANK_W]),
      .pin_sync (pin_sync[LO +: BANK_W]),
      .dir_in   (dir_in[LO +: BANK_W]),
      .int_mask (int_mask[LO +: BANK_W]),
      .rd_hit   (bank_read[b]),
      .snap     (snap_all[LO +: BANK_W]),
      .flag     (bank_flag[b])
    );
  end

  chg_irq_out #(.BANKS(BANKS)) u_out (
    .clk           (clk),
    .rst           (rst),
    .bank_flag     (bank_flag),
    .bank_read     (bank_read),
    .int_drive_low (int_drive_low)
  );
endmodule

// File: rtl/chg_irq_gen_chk.sv
module chg_irq_gen_chk #(
  parameter int BANKS  = 5,
  parameter int BANK_W = 8,
  parameter int N_PINS = BANKS * BANK_W,
  parameter int BSEL_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [N_PINS-1:0] dir_in,
  input logic [N_PINS-1:0] int_mask,
  input logic              rd_strobe,
  input logic [BSEL_W-1:0] rd_bank,
  input logic              int_drive_low,
  input logic [N_PINS-1:0] pin_sync,
  input logic [N_PINS-1:0] snap_all,
  input logic [BANKS-1:0]  bank_flag
);
  always_ff @(posedge clk) begin
    if (rst) assert_reset_release_R1: assert (int_drive_low == 1'b0 || $isunknown(int_drive_low));
  end

  assert_rise_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(int_drive_low) |-> $past(|bank_flag));

  assert_outputs_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (dir_in == '0) |=> !int_drive_low);

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (&int_mask) |=> !int_drive_low);

  assert_no_read_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> $stable(snap_all));

  assert_bad_bank_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && (int'(rd_bank) >= BANKS)) |=> $stable(snap_all));

  for (genvar b = 0; b < BANKS; b++) begin : g_rd
    assert_read_refresh_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_strobe && (int'(rd_bank) == b)) |=>
        (snap_all[b*BANK_W +: BANK_W] == $past(pin_sync[b*BANK_W +: BANK_W])));
  end
endmodule

bind chg_irq_gen chg_irq_gen_chk #(
  .BANKS(BANKS), .BANK_W(BANK_W), .N_PINS(N_PINS), .BSEL_W(BSEL_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .dir_in        (dir_in),
  .int_mask      (int_mask),
  .rd_strobe     (rd_strobe),
  .rd_bank       (rd_bank),
  .int_drive_low (int_drive_low),
  .pin_sync      (pin_sync),
  .snap_all      (snap_all),
  .bank_flag     (bank_flag)
);

// File: tb/chg_irq_gen_bench.sv
`timescale 1ns/1ps
module chg_irq_gen_bench;
  localparam int BANKS  = 5;
  localparam int BANK_W = 8;
  localparam int N      = BANKS * BANK_W;
  localparam int SW     = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pin_i = '0;
  logic [N-1:0]  dir_in = '0;
  logic [N-1:0]  int_mask = '1;
  logic          rd_strobe = 1'b0;
  logic [SW-1:0] rd_bank = '0;
  logic          int_drive_low;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chg_irq_gen u_chg_irq_gen (
    .clk           (clk),
    .rst           (rst),
    .pin_i         (pin_i),
    .dir_in        (dir_in),
    .int_mask      (int_mask),
    .rd_strobe     (rd_strobe),
    .rd_bank       (rd_bank),
    .int_drive_low (int_drive_low)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic expect_int(input logic exp, input string req);
    checks++;
    if (int_drive_low !== exp) begin
      errors++;
      $display("FAIL %s int_drive_low actual %b expected %b", req, int_drive_low, exp);
    end
  endtask

  task automatic do_read(input int bank);
    rd_strobe = 1'b1;
    rd_bank   = SW'(bank);
    tick(1);
    rd_strobe = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state and snapshot loading from pins present at reset
    pin_i = 40'hA5_3C_F0_0F_96;
    @(negedge clk);
    tick(2);
    expect_int(1'b0, "R1");
    rst = 1'b0;
    dir_in = '1;
    int_mask = '0;
    tick(4);
    expect_int(1'b0, "R1");

    // R8: a change that goes back before any read releases the request
    pin_i[13] = ~pin_i[13];
    tick(3);
    expect_int(1'b1, "R8");
    pin_i[13] = ~pin_i[13];
    tick(2);
    expect_int(1'b1, "R8");
    tick(1);
    expect_int(1'b0, "R8");

    // Sweep over every pin and every direction/mask combination
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 4; c++) begin
        automatic int  bk    = p / BANK_W;
        automatic logic d    = c[0];
        automatic logic m    = c[1];
        automatic logic qual = d & ~m;
        dir_in   = '1;
        int_mask = '0;
        dir_in[p]   = d;
        int_mask[p] = m;
        pin_i[p] = ~pin_i[p];
        tick(2);
        // R3: nothing yet after two edges
        expect_int(1'b0, "R3");
        tick(1);
        if (qual) begin
          expect_int(1'b1, "R3");
          // R7: read of a neighbouring bank keeps the request
          do_read((bk + 1) % BANKS);
          expect_int(1'b1, "R7");
          // R9: out-of-range bank number has no effect
          do_read(BANKS + (p % 3));
          expect_int(1'b1, "R9");
          tick(1);
          expect_int(1'b1, "R9");
          // R6: read of own bank releases and stays released
          do_read(bk);
          expect_int(1'b0, "R6");
          tick(2);
          expect_int(1'b0, "R6");
        end else begin
          expect_int(1'b0, d ? "R5" : "R4");
          tick(2);
          expect_int(1'b0, d ? "R5" : "R4");
          // R10: lifting the mask on a differing input shows the hidden change
          dir_in[p]   = 1'b1;
          int_mask[p] = 1'b0;
          tick(1);
          expect_int(1'b1, "R10");
          int_mask[p] = 1'b1;
          tick(1);
          expect_int(1'b0, "R10");
          int_mask[p] = 1'b0;
          do_read(bk);
          expect_int(1'b0, "R6");
        end
      end
    end

    // R5: all masks set, many pins toggling
    int_mask = '1;
    dir_in = '1;
    pin_i = ~pin_i;
    tick(4);
    expect_int(1'b0, "R5");
    // R4: all outputs, masks clear
    int_mask = '0;
    dir_in = '0;
    tick(4);
    expect_int(1'b0, "R4");
    // R2: the single enable asserts when inputs are exposed
    dir_in = '1;
    tick(1);
    expect_int(1'b1, "R2");
    for (int b = 0; b < BANKS; b++) do_read(b);
    tick(1);
    expect_int(1'b0, "R6");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule